// File: doc/BRIEF.md
# Flash Query-Mode Command Front End

This block sits between a host bus and the storage array of a parallel NOR flash model. It watches every host write for command cycles. While no command mode is active, plain writes and reads go straight through to the array port. Writing the query-entry command switches the block into query mode. In that mode, reads within the entry sector are answered from a computed identification table that describes the device. Writes are refused, and the refusal is flagged. A reset command returns the block to plain array access. An identification mode, reached by a three-write unlock sequence, returns the maker and device codes, and query mode can also be entered from it.

Command decoding looks only at the word offset and the low data byte. In byte-wide operation the bus address is halved before decoding, so every table entry and command address appears at twice its word offset. Read data comes back on a registered return path one cycle after the read strobe. There is no back-pressure: the host must take `rd_data` in the cycle `rd_valid` is high. The flash array, program and erase timing, and supply behaviour are outside this block.

Top module: `cfi_query_ctrl`

## Requirements
- R1: While `rst_n` is low, `query_active`, `autosel_active`, `rd_valid` and `wr_rejected` are 0. After reset the block is in plain array access.
- R2: A write with low data byte 98h at word offset 055h enters query mode. This works from plain array access and from identification mode. The mode shows on `query_active` from the next cycle.
- R3: A write with low data byte F0h at any address leaves query mode or identification mode and always returns to plain array access. In plain array access this write is consumed and not forwarded.
- R4: In query mode, a read in the entry sector at a word offset from 010h to 050h returns the table word. Offsets 010h/011h/012h give 0051h/0052h/0059h. Offsets 040h to 044h give 0050h, 0052h, 0049h, 0031h and 0033h. Offset 02Ch gives 0001h. An offset in that range that has no table entry (for example 031h) gives 0000h.
- R5: In query mode, a read in the entry sector at a word offset below 010h or above 050h returns FFFFh.
- R6: With `byte_mode` high, the word offset is the bus address shifted right by one. Query entry is 98h at byte address 0AAh. The table appears at twice its word offsets, for example 0051h at 020h and 0059h at 024h. A query read at an odd byte address returns FFFFh.
- R7: The sector is the word address above its low 11 offset bits. In query mode, a read in a sector other than the one given by the entry write goes to the array: `arr_re` is high in the strobe cycle and the returned word is `arr_rdata`.
- R8: In query mode, a write other than the reset command is not forwarded (`arr_we` stays 0). `wr_rejected` is high for exactly the next cycle, and the mode does not change.
- R9: Data bits 15 to 8 have no effect on command decoding.
- R10: `rd_valid` and `rd_data` are registered. They appear in the cycle after a cycle with `bus_re` high and `bus_we` low, for one cycle per strobe cycle. A cycle with both strobes high performs only the write.
- R11: Writes of AAh at 555h, then 55h at 2AAh, then 90h at 555h enter identification mode. There, reads at offset 0 return `MAKER_ID`, reads at offset 1 return `DEVICE_ID`, and reads at any other offset return 0000h. Other writes are dropped. A write that breaks the sequence restarts it and is handled as a plain write.
- R12: In plain array access, a non-command write drives `arr_we` high in the same cycle, with `arr_addr` = `bus_addr` and `arr_wdata` = `bus_wdata`. A read returns `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_mode | input | 1 | High selects byte-wide addressing (offset = address / 2) |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | 16 | Host write data |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_re | input | 1 | Host read strobe, one cycle per read |
| rd_data | output | 16 | Registered read return |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| wr_rejected | output | 1 | One-cycle flag for a write refused in query mode |
| query_active | output | 1 | Query mode is active |
| autosel_active | output | 1 | Identification mode is active |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 16 | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_rdata | input | 16 | Array read data, combinational from `arr_addr` |

## Verification
The bound checker checks the following on every cycle:
- mode entry on the query command and exit on the reset command, with the upper data byte ignored;
- the one-cycle timing of `rd_valid`;
- the rejection pulse for writes in query mode;
- the rule that the array only sees writes in plain array access.

The values of table words, the invalid marker, byte-mode address doubling, sector redirection and the unlock sequence cannot be seen that way. Only the directed scenarios show them, by comparing returned words against expected constants.

// File: rtl/cfi_query_pkg.sv
package cfi_query_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_ASEL  = 2'd1,
    MODE_QUERY = 2'd2
  } flash_mode_e;

  typedef enum logic [1:0] {
    UNLK_IDLE = 2'd0,
    UNLK_ONE  = 2'd1,
    UNLK_TWO  = 2'd2
  } unlock_step_e;

  // command opcodes (low data byte only)
  localparam logic [7:0] OP_QUERY  = 8'h98;
  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_UNLK_A = 8'hAA;
  localparam logic [7:0] OP_UNLK_B = 8'h55;
  localparam logic [7:0] OP_ASEL   = 8'h90;

  // word offsets that commands are decoded at
  localparam int unsigned ADR_QUERY  = 'h055;
  localparam int unsigned ADR_UNLK_A = 'h555;
  localparam int unsigned ADR_UNLK_B = 'h2AA;

  // implemented table window
  localparam int unsigned TBL_LO = 'h10;
  localparam int unsigned TBL_HI = 'h50;

  localparam logic [15:0] INVALID_WORD = 16'hFFFF;

endpackage

// File: rtl/cfi_cmd_decode.sv
module cfi_cmd_decode
  import cfi_query_pkg::*;
#(
  parameter int unsigned OFS_W = 11
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       op,
  output logic             hit_query,
  output logic             hit_reset,
  output logic             hit_unlk_a,
  output logic             hit_unlk_b,
  output logic             hit_asel
);

  localparam logic [OFS_W-1:0] OFS_QUERY  = OFS_W'(ADR_QUERY);
  localparam logic [OFS_W-1:0] OFS_UNLK_A = OFS_W'(ADR_UNLK_A);
  localparam logic [OFS_W-1:0] OFS_UNLK_B = OFS_W'(ADR_UNLK_B);

  logic at_query, at_unlk_a, at_unlk_b;

  always_comb begin
    at_query   = (ofs == OFS_QUERY);
    at_unlk_a  = (ofs == OFS_UNLK_A);
    at_unlk_b  = (ofs == OFS_UNLK_B);
    hit_query  = at_query  && (op == OP_QUERY);
    hit_reset  = (op == OP_RESET);
    hit_unlk_a = at_unlk_a && (op == OP_UNLK_A);
    hit_unlk_b = at_unlk_b && (op == OP_UNLK_B);
    hit_asel   = at_unlk_a && (op == OP_ASEL);
  end

endmodule

// File: rtl/cfi_mode_fsm.sv
module cfi_mode_fsm
  import cfi_query_pkg::*;
#(
  parameter int unsigned SEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             hit_query,
  input  logic             hit_reset,
  input  logic             hit_unlk_a,
  input  logic             hit_unlk_b,
  input  logic             hit_asel,
  input  logic [SEC_W-1:0] sec,
  output flash_mode_e      mode,
  output logic [SEC_W-1:0] entry_sec,
  output logic             fwd_write,
  output logic             reject
);

  flash_mode_e      mode_q, mode_d;
  unlock_step_e     step_q, step_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             rej_d, rej_q;

  always_comb begin
    mode_d    = mode_q;
    step_d    = step_q;
    sec_d     = sec_q;
    rej_d     = 1'b0;
    fwd_write = 1'b0;
    if (wr) begin
      unique case (mode_q)
        MODE_ARRAY: begin
          if (hit_query) begin
            mode_d = MODE_QUERY;
            sec_d  = sec;
            step_d = UNLK_IDLE;
          end else if (hit_reset) begin
            step_d = UNLK_IDLE;
          end else if (step_q == UNLK_ONE && hit_unlk_b) begin
            step_d = UNLK_TWO;
          end else if (step_q == UNLK_TWO && hit_asel) begin
            mode_d = MODE_ASEL;
            step_d = UNLK_IDLE;
          end else if (hit_unlk_a) begin
            step_d = UNLK_ONE;
          end else begin
            step_d    = UNLK_IDLE;
            fwd_write = 1'b1;
          end
        end
        MODE_ASEL: begin
          if (hit_query) begin
            mode_d = MODE_QUERY;
            sec_d  = sec;
          end else if (hit_reset) begin
            mode_d = MODE_ARRAY;
          end
        end
        MODE_QUERY: begin
          if (hit_reset) begin
            mode_d = MODE_ARRAY;
          end else begin
            rej_d = 1'b1;
          end
        end
        default: begin
          mode_d = MODE_ARRAY;
          step_d = UNLK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      step_q <= UNLK_IDLE;
      sec_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      step_q <= step_d;
      sec_q  <= sec_d;
      rej_q  <= rej_d;
    end
  end

  assign mode      = mode_q;
  assign entry_sec = sec_q;
  assign reject    = rej_q;

endmodule

// File: rtl/cfi_id_rom.sv
module cfi_id_rom
  import cfi_query_pkg::*;
#(
  parameter int unsigned OFS_W      = 11,
  parameter logic [15:0] MAKER_ID   = 16'h0001,
  parameter logic [15:0] DEVICE_ID  = 16'h7E21,
  parameter logic [7:0]  SIZE_LOG2  = 8'h1A,
  parameter logic [7:0]  CHIP_ERASE = 8'h12,
  parameter logic [15:0] BLK_COUNT  = 16'h01FF,
  parameter logic [7:0]  WP_STYLE   = 8'h04
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             odd,
  output logic [15:0]      q_word,
  output logic [15:0]      a_word
);

  localparam logic [OFS_W-1:0] OFS_LO = OFS_W'(TBL_LO);
  localparam logic [OFS_W-1:0] OFS_HI = OFS_W'(TBL_HI);

  logic       in_window;
  logic [7:0] tbl;

  // table body, indexed by the low seven offset bits inside the window
  always_comb begin
    unique case (ofs[6:0])
      7'h10: tbl = 8'h51;
      7'h11: tbl = 8'h52;
      7'h12: tbl = 8'h59;
      7'h13: tbl = 8'h02;
      7'h15: tbl = 8'h40;
      7'h1B: tbl = 8'h27;
      7'h1C: tbl = 8'h36;
      7'h1F: tbl = 8'h06;
      7'h20: tbl = 8'h06;
      7'h21: tbl = 8'h09;
      7'h22: tbl = CHIP_ERASE;
      7'h23: tbl = 8'h03;
      7'h24: tbl = 8'h05;
      7'h25: tbl = 8'h03;
      7'h27: tbl = SIZE_LOG2;
      7'h28: tbl = 8'h02;
      7'h2A: tbl = 8'h06;
      7'h2C: tbl = 8'h01;
      7'h2D: tbl = BLK_COUNT[7:0];
      7'h2E: tbl = BLK_COUNT[15:8];
      7'h30: tbl = 8'h02;
      7'h40: tbl = 8'h50;
      7'h41: tbl = 8'h52;
      7'h42: tbl = 8'h49;
      7'h43: tbl = 8'h31;
      7'h44: tbl = 8'h33;
      7'h45: tbl = 8'h14;
      7'h46: tbl = 8'h02;
      7'h47: tbl = 8'h01;
      7'h49: tbl = 8'h08;
      7'h4C: tbl = 8'h02;
      7'h4D: tbl = 8'hB5;
      7'h4E: tbl = 8'hC5;
      7'h4F: tbl = WP_STYLE;
      7'h50: tbl = 8'h01;
      default: tbl = 8'h00;
    endcase
  end

  always_comb begin
    in_window = (ofs >= OFS_LO) && (ofs <= OFS_HI);
    q_word    = (in_window && !odd) ? {8'h00, tbl} : INVALID_WORD;
    if (ofs == '0)
      a_word = MAKER_ID;
    else if (ofs == OFS_W'(1))
      a_word = DEVICE_ID;
    else
      a_word = 16'h0000;
  end

endmodule

// File: rtl/cfi_read_path.sv
module cfi_read_path
  import cfi_query_pkg::*;
#(
  parameter int unsigned SEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re,
  input  logic             we,
  input  flash_mode_e      mode,
  input  logic [SEC_W-1:0] sec,
  input  logic [SEC_W-1:0] entry_sec,
  input  logic [15:0]      q_word,
  input  logic [15:0]      a_word,
  input  logic [15:0]      arr_rdata,
  output logic             arr_re,
  output logic [15:0]      rd_data,
  output logic             rd_valid
);

  logic        take;
  logic        to_array;
  logic [15:0] word_d;

  always_comb begin
    take     = re && !we;
    to_array = (mode == MODE_ARRAY) ||
               ((mode == MODE_QUERY) && (sec != entry_sec));
    arr_re   = take && to_array;
    if (to_array)
      word_d = arr_rdata;
    else if (mode == MODE_QUERY)
      word_d = q_word;
    else
      word_d = a_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take;
      if (take)
        rd_data <= word_d;
    end
  end

endmodule

// File: rtl/cfi_query_ctrl.sv
module cfi_query_ctrl
  import cfi_query_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned OFS_W     = 11,
  parameter logic [15:0] MAKER_ID  = 16'h0001,
  parameter logic [15:0] DEVICE_ID = 16'h7E21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              wr_rejected,
  output logic              query_active,
  output logic              autosel_active,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [15:0]       arr_wdata,
  output logic              arr_we,
  output logic              arr_re,
  input  logic [15:0]       arr_rdata
);

  localparam int unsigned SEC_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] eff_addr;
  logic [OFS_W-1:0]  ofs;
  logic [SEC_W-1:0]  sec;
  logic              odd;
  logic hit_query, hit_reset, hit_unlk_a, hit_unlk_b, hit_asel;
  flash_mode_e       mode;
  logic [SEC_W-1:0]  entry_sec;
  logic [15:0]       q_word, a_word;

  always_comb begin
    eff_addr = byte_mode ? {1'b0, bus_addr[ADDR_W-1:1]} : bus_addr;
    odd      = byte_mode && bus_addr[0];
  end

  assign ofs = eff_addr[OFS_W-1:0];
  assign sec = eff_addr[ADDR_W-1:OFS_W];

  cfi_cmd_decode #(.OFS_W(OFS_W)) u_dec (
    .ofs       (ofs),
    .op        (bus_wdata[7:0]),
    .hit_query (hit_query),
    .hit_reset (hit_reset),
    .hit_unlk_a(hit_unlk_a),
    .hit_unlk_b(hit_unlk_b),
    .hit_asel  (hit_asel)
  );

  cfi_mode_fsm #(.SEC_W(SEC_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_we),
    .hit_query (hit_query),
    .hit_reset (hit_reset),
    .hit_unlk_a(hit_unlk_a),
    .hit_unlk_b(hit_unlk_b),
    .hit_asel  (hit_asel),
    .sec       (sec),
    .mode      (mode),
    .entry_sec (entry_sec),
    .fwd_write (arr_we),
    .reject    (wr_rejected)
  );

  cfi_id_rom #(
    .OFS_W    (OFS_W),
    .MAKER_ID (MAKER_ID),
    .DEVICE_ID(DEVICE_ID)
  ) u_rom (
    .ofs   (ofs),
    .odd   (odd),
    .q_word(q_word),
    .a_word(a_word)
  );

  cfi_read_path #(.SEC_W(SEC_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .re       (bus_re),
    .we       (bus_we),
    .mode     (mode),
    .sec      (sec),
    .entry_sec(entry_sec),
    .q_word   (q_word),
    .a_word   (a_word),
    .arr_rdata(arr_rdata),
    .arr_re   (arr_re),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign arr_addr       = bus_addr;
  assign arr_wdata      = bus_wdata;
  assign query_active   = (mode == MODE_QUERY);
  assign autosel_active = (mode == MODE_ASEL);

endmodule

// File: rtl/cfi_query_ctrl_chk.sv
module cfi_query_ctrl_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned OFS_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              rd_valid,
  input logic              wr_rejected,
  input logic              query_active,
  input logic              autosel_active,
  input logic              arr_we
);

  logic [OFS_W-1:0] c_ofs;
  logic             c_entry;
  logic             c_exit;

  always_comb begin
    c_ofs   = byte_mode ? bus_addr[OFS_W:1] : bus_addr[OFS_W-1:0];
    c_entry = bus_we && (bus_wdata[7:0] == 8'h98) && (c_ofs == OFS_W'('h55));
    c_exit  = bus_we && (bus_wdata[7:0] == 8'hF0);
  end

  // R2 R9
  query_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_entry |=> query_active);

  // R3 R9
  query_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_exit |=> (!query_active && !autosel_active));

  // R8
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_active && bus_we && !c_exit) |=> (wr_rejected && query_active));

  // R8
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rejected |-> $past(bus_we && query_active));

  // R10
  rd_valid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we) |=> rd_valid);

  // R10
  rd_valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && !bus_we) |=> !rd_valid);

  // R12 R8
  array_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (bus_we && !query_active && !autosel_active));

  // R2
  mode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(query_active && autosel_active));

endmodule

bind cfi_query_ctrl cfi_query_ctrl_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_mode     (byte_mode),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_we        (bus_we),
  .bus_re        (bus_re),
  .rd_valid      (rd_valid),
  .wr_rejected   (wr_rejected),
  .query_active  (query_active),
  .autosel_active(autosel_active),
  .arr_we        (arr_we)
);

// File: tb/sim_cfi_query_ctrl.sv
module sim_cfi_query_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int WD_CYCLES  = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              byte_mode = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [15:0]       rd_data;
  logic              rd_valid, wr_rejected, query_active, autosel_active;
  logic [ADDR_W-1:0] arr_addr;
  logic [15:0]       arr_wdata, arr_rdata;
  logic              arr_we, arr_re;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // array model: data is a fixed function of the address
  assign arr_rdata = arr_addr[15:0] ^ 16'hA5A5;

  cfi_query_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_rejected(wr_rejected),
    .query_active(query_active), .autosel_active(autosel_active),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_re(arr_re),
    .arr_rdata(arr_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input bit exp_fwd, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #1;
    check(arr_we == exp_fwd, tag, arr_we, exp_fwd);
    if (exp_fwd)
      check(arr_wdata == d && arr_addr == a, {tag, " R12 path"}, arr_wdata, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(rd_valid == 1'b1, {tag, " R10 valid"}, rd_valid, 1);
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!query_active && !autosel_active && !rd_valid && !wr_rejected,
          "R1 reset outputs", {query_active, autosel_active, rd_valid, wr_rejected}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!query_active, "R1 idle after reset", query_active, 0);
  endtask

  task automatic t_array();
    bus_write(20'h00123, 16'h4321, 1'b1, "R12 plain write forwarded");
    bus_read(20'h00123, 16'h0123 ^ 16'hA5A5, "R12 plain read");
    bus_write(20'h00000, 16'h00F0, 1'b0, "R3 reset consumed in array mode");
    // both strobes: only the write
    @(negedge clk);
    bus_addr = 20'h00200; bus_wdata = 16'h1111; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check(rd_valid == 1'b0, "R10 read ignored with write", rd_valid, 0);
    @(negedge clk);
    check(rd_valid == 1'b0, "R10 single pulse", rd_valid, 0);
  endtask

  task automatic t_query_word();
    bus_write(20'h00055, 16'h3498, 1'b0, "R2 entry not forwarded");
    check(query_active, "R2 R9 entry with upper byte set", query_active, 1);
    bus_read(20'h00010, 16'h0051, "R4 off 10");
    bus_read(20'h00011, 16'h0052, "R4 off 11");
    bus_read(20'h00012, 16'h0059, "R4 off 12");
    bus_read(20'h00040, 16'h0050, "R4 off 40");
    bus_read(20'h00042, 16'h0049, "R4 off 42");
    bus_read(20'h00043, 16'h0031, "R4 off 43");
    bus_read(20'h00044, 16'h0033, "R4 off 44");
    bus_read(20'h0002C, 16'h0001, "R4 off 2C");
    bus_read(20'h00031, 16'h0000, "R4 empty slot");
    bus_read(20'h0000F, 16'hFFFF, "R5 below window");
    bus_read(20'h00051, 16'hFFFF, "R5 above window");
    bus_read(20'h00000, 16'hFFFF, "R5 offset 0");
  endtask

  task automatic t_reject();
    bus_write(20'h00100, 16'h1234, 1'b0, "R8 write blocked");
    check(wr_rejected == 1'b1, "R8 pulse", wr_rejected, 1);
    check(query_active, "R8 mode kept", query_active, 1);
    @(negedge clk);
    check(wr_rejected == 1'b0, "R8 pulse one cycle", wr_rejected, 0);
    bus_write(20'h00555, 16'h00AA, 1'b0, "R8 unlock blocked");
    check(wr_rejected && query_active, "R8 unlock rejected", {wr_rejected, query_active}, 3);
    bus_write(20'h7ABCD, 16'h5AF0, 1'b0, "R3 exit write");
    check(!query_active && !autosel_active, "R3 R9 back to array", query_active, 0);
    check(wr_rejected == 1'b0, "R8 exit not rejected", wr_rejected, 0);
    bus_read(20'h00010, 16'h0010 ^ 16'hA5A5, "R3 array read after exit");
  endtask

  task automatic t_sector();
    bus_write(20'h00855, 16'h0098, 1'b0, "R7 entry in sector 1");
    bus_read(20'h00810, 16'h0051, "R7 same sector table");
    @(negedge clk);
    bus_addr = 20'h00010; bus_re = 1'b1;
    #1;
    check(arr_re == 1'b1, "R7 arr_re other sector", arr_re, 1);
    @(negedge clk);
    bus_re = 1'b0;
    check(rd_data == (16'h0010 ^ 16'hA5A5), "R7 other sector data", rd_data, 16'h0010 ^ 16'hA5A5);
    bus_write(20'h00000, 16'h00F0, 1'b0, "R3 exit");
  endtask

  task automatic t_byte();
    byte_mode = 1'b1;
    bus_write(20'h000AA, 16'h0098, 1'b0, "R6 byte entry");
    check(query_active, "R6 entry at doubled address", query_active, 1);
    bus_read(20'h00020, 16'h0051, "R6 byte 20");
    bus_read(20'h00024, 16'h0059, "R6 byte 24");
    bus_read(20'h00080, 16'h0050, "R6 byte 80");
    bus_read(20'h00021, 16'hFFFF, "R6 odd byte");
    bus_write(20'h00000, 16'h00F0, 1'b0, "R3 byte exit");
    check(!query_active, "R6 exit", query_active, 0);
    byte_mode = 1'b0;
  endtask

  task automatic t_autosel();
    bus_write(20'h00555, 16'hFFAA, 1'b0, "R11 R9 unlock a");
    bus_write(20'h002AA, 16'h0055, 1'b0, "R11 unlock b");
    bus_write(20'h00555, 16'h0090, 1'b0, "R11 select");
    check(autosel_active && !query_active, "R11 ident mode", autosel_active, 1);
    bus_read(20'h00000, 16'h0001, "R11 maker");
    bus_read(20'h00001, 16'h7E21, "R11 device");
    bus_read(20'h00002, 16'h0000, "R11 other");
    bus_write(20'h00300, 16'h7777, 1'b0, "R11 write dropped");
    check(!wr_rejected && autosel_active, "R11 no reject", wr_rejected, 0);
    bus_write(20'h00055, 16'h0098, 1'b0, "R2 entry from ident");
    check(query_active && !autosel_active, "R2 query from ident", query_active, 1);
    bus_read(20'h00012, 16'h0059, "R4 from ident entry");
    bus_write(20'h00000, 16'h00F0, 1'b0, "R3 exit");
    check(!query_active && !autosel_active, "R3 returns to array not ident",
          {query_active, autosel_active}, 0);
    // broken sequence
    bus_write(20'h00555, 16'h00AA, 1'b0, "R11 broken a");
    bus_write(20'h00100, 16'h1234, 1'b1, "R11 breaker forwarded");
    bus_write(20'h002AA, 16'h0055, 1'b1, "R11 b after break forwarded");
    bus_write(20'h00555, 16'h0090, 1'b1, "R11 select after break forwarded");
    check(!autosel_active, "R11 no ident after break", autosel_active, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_array();
    t_query_word();
    t_reject();
    t_sector();
    t_byte();
    t_autosel();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule